// File: doc/BRIEF.md
# Asynchronous DRAM Controller (64K x 16, byte-lane strobes)

This block sits between a synchronous host and a 64K x 16 asynchronous DRAM whose address pins are shared between row and column. The host hands over one word access at a time through a valid/ready request channel: a write flag, a 16-bit word address, 16 bits of write data and a 2-bit byte-enable mask. The controller sends the top address byte as the row and the bottom byte as the column. It drives the row strobe, the two column strobes (one for each data byte), write enable and output enable, and returns read data on a one-cycle response pulse.

Every DRAM timing limit is a whole number of controller clocks, set by a parameter. The refresh interval and the power-up pause default to values worked out from a 50 MHz clock. After reset the controller holds the row strobe high for the power-up pause. It then runs eight refresh cycles, and only after those does it raise `req_ready`. From then on an interval timer marks a refresh as due every 4 ms / 256, rounded down to whole clocks. A due refresh is served before any waiting host request, but it never cuts short an access that has already started. Each refresh is a strobe-before-row cycle: both column strobes go low, then the row strobe falls. The DRAM's own row counter chooses the row.

Back-pressure: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. All request fields are captured on that edge. The host must hold `req_valid` and the fields steady while `req_ready` is low. `req_ready` stays low during power-up, initialization, any refresh, and any access in flight. The response channel has no ready input. Each read produces exactly one `rsp_valid` pulse, in request order, and a write produces none.

Top module: `dramc_top`

## Requirements
- R1: After reset, `dram_ras_n`, both column strobes and `dram_oe_n` are high and `req_ready` is low. The row strobe stays high for at least T_PWRUP clocks. Exactly eight refresh cycles then complete before `req_ready` first goes high.
- R2: For an access, `dram_addr` carries `req_addr[15:8]` when the row strobe falls and `req_addr[7:0]` when the column strobe falls.
- R3: Byte enable bit 0 drives the low strobe `dram_lcas_n` (data bits 7..0) and bit 1 drives the high strobe `dram_ucas_n` (bits 15..8). Only the enabled strobes fall. Read data bits in a lane that is not enabled are returned as 0.
- R4: The row strobe stays low for at least T_RAS clocks in every cycle, whether access or refresh.
- R5: Between two cycles, the row strobe stays high for at least T_RP clocks.
- R6: For a write, `dram_we_n` is low and `dram_dq_oe` is high with the write data on `dram_dq_o` at least one clock before any column strobe falls. They stay that way while the strobe is low.
- R7: For a read, `dram_we_n` stays high and `dram_oe_n` is low while the column strobes are low. The data is captured after the strobes have been low for at least T_CAS clocks.
- R8: In a refresh cycle, both column strobes are low for at least T_CSR clocks before the row strobe falls. `dram_oe_n` and `dram_we_n` stay high and `dram_dq_oe` stays low.
- R9: After initialization, refresh cycles start every T_REFI clocks while the host is idle. T_REFI defaults to floor(f_clk x 4 ms / 256), which is 781 at 50 MHz.
- R10: A due refresh is started before a waiting host request. `req_ready` is low while the refresh is due or running. During traffic the gap between refreshes never exceeds T_REFI plus one access.
- R11: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low while an access is in flight. Exactly one DRAM access is made per accepted request.
- R12: Each accepted read gives exactly one single-cycle `rsp_valid` pulse, in request order, and a write gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address; [15:8] row, [7:0] column |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables; bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Low-byte column strobe, active low |
| dram_ucas_n | output | 1 | High-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | 16 | Write data to the data pins |
| dram_dq_oe | output | 1 | Enable for the external data-pin drivers |
| dram_dq_i | input | 16 | Data read from the data pins |

## Verification
The hardest case to reach from the ports is a refresh falling due while a host request is already waiting, or while an access is partway through its strobe sequence. Only that case exercises the refresh priority and the rule that an access is never interrupted. The bench shortens the refresh interval and then drives a long back-to-back mix of reads, writes and byte-lane accesses, with pseudo-random gaps. This lets the timer expire at every phase of an access and while `req_valid` is held high against a low `req_ready`. A DRAM model in the bench checks every strobe edge against the timing counts. It also measures the spacing between refreshes and compares the address halves it latches with those the driver sent.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_ROW,
    ST_RCD,
    ST_COL,
    ST_CASL,
    ST_PRE,
    ST_CBRC,
    ST_CBRR
  } dramc_st_e;

  function automatic int dmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dramc_pwrup.sv
module dramc_pwrup #(
  parameter int T_PWRUP = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int PW_W = $clog2(T_PWRUP + 1);

  logic [PW_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == PW_W'(T_PWRUP - 1)) done <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  a_r1_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/dramc_reftmr.sv
module dramc_reftmr #(
  parameter int T_REFI = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pend
);
  localparam int RI_W = $clog2(T_REFI + 1);

  logic [RI_W-1:0] cnt;
  logic            wrap;

  assign wrap = en && (cnt == RI_W'(T_REFI - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (en) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end

  // R9: a request is only raised while the timer is enabled
  a_r9_no_pend_before_init: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pend);
endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 2,
  parameter int T_RAS    = 4,
  parameter int T_RP     = 2,
  parameter int T_CSR    = 1,
  parameter int INIT_CYC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pwrup_done,
  input  logic                     ref_pend,
  output logic                     ref_ack,
  output logic                     init_done,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W/8-1:0]      req_be,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W/2-1:0]      dram_addr,
  output logic                     dram_ras_n,
  output logic [DATA_W/8-1:0]      dram_cas_n,
  output logic                     dram_we_n,
  output logic                     dram_oe_n,
  output logic [DATA_W-1:0]        dram_dq_o,
  output logic                     dram_dq_oe,
  input  logic [DATA_W-1:0]        dram_dq_i
);
  localparam int LANES  = DATA_W / 8;
  localparam int RA_W   = ADDR_W / 2;
  localparam int CASL_N = dmax(T_CAS, T_RAS - T_RCD - 1);
  localparam int MAXT   = dmax(dmax(dmax(T_RCD, CASL_N), dmax(T_RAS, T_RP)), T_CSR);
  localparam int CNT_W  = $clog2(MAXT + 1);
  localparam int INIT_W = $clog2(INIT_CYC + 1);
  localparam int RUN_W  = CNT_W + 2;

  dramc_st_e         st;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_zero;
  logic [INIT_W-1:0] init_cnt;
  logic [RA_W-1:0]   col_q;
  logic [LANES-1:0]  be_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] lane_mask;
  logic              want_ref;

  assign cnt_zero  = (cnt == '0);
  assign want_ref  = !init_done || ref_pend;
  assign req_ready = (st == ST_IDLE) && init_done && !ref_pend;
  assign ref_ack   = (st == ST_IDLE) && init_done && ref_pend;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*8 +: 8] = {8{be_q[l]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_PWRUP;
      cnt        <= '0;
      init_cnt   <= '0;
      init_done  <= 1'b0;
      col_q      <= '0;
      be_q       <= '0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      dram_addr  <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= '1;
      dram_we_n  <= 1'b1;
      dram_oe_n  <= 1'b1;
      dram_dq_o  <= '0;
      dram_dq_oe <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (!cnt_zero) cnt <= cnt - 1'b1;
      unique case (st)
        ST_PWRUP: if (pwrup_done) st <= ST_IDLE;
        ST_IDLE: begin
          if (want_ref) begin
            dram_cas_n <= '0;
            cnt        <= CNT_W'(T_CSR - 1);
            st         <= ST_CBRC;
          end else if (req_valid) begin
            dram_addr <= req_addr[ADDR_W-1:RA_W];
            col_q     <= req_addr[RA_W-1:0];
            be_q      <= req_be;
            wr_q      <= req_write;
            wdata_q   <= req_wdata;
            st        <= ST_ROW;
          end
        end
        ST_ROW: begin
          dram_ras_n <= 1'b0;
          cnt        <= CNT_W'(T_RCD - 1);
          st         <= ST_RCD;
        end
        ST_RCD: if (cnt_zero) begin
          dram_addr  <= col_q;
          dram_we_n  <= !wr_q;
          dram_dq_oe <= wr_q;
          dram_dq_o  <= wdata_q;
          st         <= ST_COL;
        end
        ST_COL: begin
          dram_cas_n <= ~be_q;
          dram_oe_n  <= wr_q;
          cnt        <= CNT_W'(CASL_N - 1);
          st         <= ST_CASL;
        end
        ST_CASL: if (cnt_zero) begin
          dram_ras_n <= 1'b1;
          dram_cas_n <= '1;
          dram_oe_n  <= 1'b1;
          dram_we_n  <= 1'b1;
          dram_dq_oe <= 1'b0;
          if (!wr_q) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= dram_dq_i & lane_mask;
          end
          cnt <= CNT_W'(T_RP - 1);
          st  <= ST_PRE;
        end
        ST_PRE: if (cnt_zero) st <= ST_IDLE;
        ST_CBRC: if (cnt_zero) begin
          dram_ras_n <= 1'b0;
          cnt        <= CNT_W'(T_RAS - 1);
          st         <= ST_CBRR;
        end
        ST_CBRR: if (cnt_zero) begin
          dram_ras_n <= 1'b1;
          dram_cas_n <= '1;
          cnt        <= CNT_W'(T_RP - 1);
          st         <= ST_PRE;
          if (!init_done) begin
            if (init_cnt == INIT_W'(INIT_CYC - 1)) init_done <= 1'b1;
            init_cnt <= init_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Strobe run-length counters, used only by the checks below
  logic [RUN_W-1:0] ras_lo_run, ras_hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_lo_run <= '0;
      ras_hi_run <= '0;
    end else begin
      ras_lo_run <= dram_ras_n ? '0 : ((&ras_lo_run) ? ras_lo_run : ras_lo_run + 1'b1);
      ras_hi_run <= !dram_ras_n ? '0 : ((&ras_hi_run) ? ras_hi_run : ras_hi_run + 1'b1);
    end
  end

  a_r4_ras_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (ras_lo_run >= RUN_W'(T_RAS)));
  a_r5_ras_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi_run >= RUN_W'(T_RP)));
  a_r6_write_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(dram_cas_n[0]) || $fell(dram_cas_n[LANES-1])) && !dram_we_n)
      |-> ($past(!dram_we_n) && $past(dram_dq_oe)));
  a_r8_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && (dram_cas_n == '0))
      |-> (dram_oe_n && dram_we_n && !dram_dq_oe && $past(dram_cas_n == '0)));
  a_r10_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && init_done && ref_pend) |=> (st == ST_CBRC));
  a_r12_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/dramc_top.sv
module dramc_top #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CLK_KHZ    = 50000,
  parameter int REF_WIN_US = 4000,
  parameter int REF_ROWS   = 256,
  parameter int PWRUP_US   = 200,
  parameter int T_PWRUP    = (CLK_KHZ * PWRUP_US) / 1000,
  parameter int T_REFI     = ((CLK_KHZ / 1000) * REF_WIN_US) / REF_ROWS,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_RAS      = 4,
  parameter int T_RP       = 2,
  parameter int T_CSR      = 1,
  parameter int INIT_CYC   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W/8-1:0]  req_be,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [ADDR_W/2-1:0]  dram_addr,
  output logic                 dram_ras_n,
  output logic                 dram_lcas_n,
  output logic                 dram_ucas_n,
  output logic                 dram_we_n,
  output logic                 dram_oe_n,
  output logic [DATA_W-1:0]    dram_dq_o,
  output logic                 dram_dq_oe,
  input  logic [DATA_W-1:0]    dram_dq_i
);
  localparam int LANES = DATA_W / 8;

  logic             pwrup_done;
  logic             ref_pend;
  logic             ref_ack;
  logic             init_done;
  logic [LANES-1:0] cas_n;

  dramc_pwrup #(.T_PWRUP(T_PWRUP)) u_pwrup (
    .clk  (clk),
    .rst_n(rst_n),
    .done (pwrup_done)
  );

  dramc_reftmr #(.T_REFI(T_REFI)) u_reftmr (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (init_done),
    .ack  (ref_ack),
    .pend (ref_pend)
  );

  dramc_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR), .INIT_CYC(INIT_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrup_done(pwrup_done),
    .ref_pend  (ref_pend),
    .ref_ack   (ref_ack),
    .init_done (init_done),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .dram_addr (dram_addr),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(cas_n),
    .dram_we_n (dram_we_n),
    .dram_oe_n (dram_oe_n),
    .dram_dq_o (dram_dq_o),
    .dram_dq_oe(dram_dq_oe),
    .dram_dq_i (dram_dq_i)
  );

  assign dram_lcas_n = cas_n[0];
  assign dram_ucas_n = cas_n[LANES-1];

  // R1: the row strobe is quiet for the whole power-up pause
  a_r1_ras_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrup_done |-> dram_ras_n);
  a_r11_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> !req_ready);
endmodule

// File: tb/sim_dramc_top.sv
`timescale 1ns/1ps
module sim_dramc_top;
  localparam int T_PWRUP = 300;
  localparam int T_REFI  = 120;
  localparam int T_RAS   = 4;
  localparam int T_RP    = 2;
  localparam int T_CAS   = 2;
  localparam int T_CSR   = 1;
  localparam int ACC_MAX = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_o, dram_dq_i;

  always #2.5 clk = ~clk;

  dramc_top #(.T_PWRUP(T_PWRUP), .T_REFI(T_REFI)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_o(dram_dq_o),
    .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fill(input int a);
    return 16'(a) ^ 16'h5A3C ^ {8'(a), 8'h00};
  endfunction

  // ---------------- DRAM model ----------------
  logic [15:0] mem [int];
  logic [15:0] mdl_dq = '0;
  int   cyc = 0, cbr_count = 0, acc_count = 0, first_ras_cyc = -1;
  int   last_cbr = -1, prev_cbr = -1;
  int   ras_lo_run = 0, ras_hi_run = 0, both_lo_run = 0;
  bit   prev_ras = 1, prev_l = 1, prev_u = 1, prev_we = 1, prev_oe_dq = 0, in_acc = 0;
  logic [7:0]  row_q;
  logic [7:0]  exp_row, exp_col;
  logic [1:0]  exp_be;
  logic        exp_wr;

  assign dram_dq_i = {(!dram_ucas_n && !dram_oe_n) ? mdl_dq[15:8] : 8'h00,
                      (!dram_lcas_n && !dram_oe_n) ? mdl_dq[7:0]  : 8'h00};

  always @(posedge clk) if (rst_n) cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dram_ras_n && prev_ras) begin
        if (first_ras_cyc < 0) begin
          first_ras_cyc = cyc;
          check(cyc >= T_PWRUP, "R1 power-up pause", cyc, T_PWRUP);
        end
        check(ras_hi_run >= T_RP, "R5 row precharge", ras_hi_run, T_RP);
        if (!dram_lcas_n && !dram_ucas_n) begin
          cbr_count++;
          check(both_lo_run >= T_CSR, "R8 strobe-before-row setup", both_lo_run, T_CSR);
          check(dram_oe_n && dram_we_n && !dram_dq_oe, "R8 refresh quiet",
                {dram_oe_n, dram_we_n, dram_dq_oe}, 3'b110);
          check(!req_ready, "R10 ready low in refresh", req_ready, 0);
          prev_cbr = last_cbr;
          last_cbr = cyc;
          if (cbr_count > 9)
            check(last_cbr - prev_cbr <= T_REFI + ACC_MAX, "R10 refresh gap bound",
                  last_cbr - prev_cbr, T_REFI + ACC_MAX);
        end else begin
          acc_count++;
          in_acc = 1;
          row_q  = dram_addr;
          check(cbr_count >= 8, "R1 init before access", cbr_count, 8);
          check(dram_addr == exp_row, "R2 row half", dram_addr, exp_row);
        end
        ras_lo_run = 1;
      end else if (!dram_ras_n) ras_lo_run++;
      if (dram_ras_n && !prev_ras) begin
        check(ras_lo_run >= T_RAS, "R4 row active time", ras_lo_run, T_RAS);
        in_acc = 0;
        ras_hi_run = 1;
      end else if (dram_ras_n) ras_hi_run++;

      if (dram_ras_n && !dram_lcas_n && !dram_ucas_n) both_lo_run++;
      else both_lo_run = 0;

      if (in_acc && !dram_ras_n && ((prev_l && !dram_lcas_n) || (prev_u && !dram_ucas_n))) begin
        check(dram_addr == exp_col, "R2 column half", dram_addr, exp_col);
        check({!dram_ucas_n, !dram_lcas_n} == exp_be, "R3 lane strobes",
              {!dram_ucas_n, !dram_lcas_n}, exp_be);
        if (exp_wr) begin
          check(!dram_we_n && !prev_we && prev_oe_dq && dram_dq_oe, "R6 write setup",
                {dram_we_n, prev_we, prev_oe_dq, dram_dq_oe}, 4'b0011);
          begin
            int a;
            logic [15:0] w;
            a = {row_q, dram_addr};
            w = mem.exists(a) ? mem[a] : fill(a);
            if (!dram_lcas_n) w[7:0]  = dram_dq_o[7:0];
            if (!dram_ucas_n) w[15:8] = dram_dq_o[15:8];
            mem[a] = w;
          end
        end else begin
          int a;
          check(dram_we_n && !dram_oe_n, "R7 read strobes", {dram_we_n, dram_oe_n}, 2'b10);
          a = {row_q, dram_addr};
          mdl_dq = mem.exists(a) ? mem[a] : fill(a);
        end
      end
      prev_ras   = dram_ras_n;
      prev_l     = dram_lcas_n;
      prev_u     = dram_ucas_n;
      prev_we    = dram_we_n;
      prev_oe_dq = dram_dq_oe;
    end
  end

  // ---------------- scoreboard ----------------
  logic [15:0] shadow [int];
  logic [15:0] expq [$];
  int n_acc = 0, n_rd = 0, n_rsp = 0;

  task automatic drive(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    exp_row = a[15:8]; exp_col = a[7:0]; exp_be = be; exp_wr = wr;
    begin
      int ai;
      logic [15:0] cur;
      ai  = a;
      cur = shadow.exists(ai) ? shadow[ai] : fill(ai);
      if (wr) begin
        if (be[0]) cur[7:0]  = d[7:0];
        if (be[1]) cur[15:8] = d[15:8];
        shadow[ai] = cur;
      end else begin
        expq.push_back(cur & {{8{be[1]}}, {8{be[0]}}});
        n_rd++;
      end
    end
    n_acc++;
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R11 ready low after accept", req_ready, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_rsp++;
      if (expq.size() == 0) check(0, "R12 unexpected response", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        check(rsp_rdata == e, "R3/R7 read data", rsp_rdata, e);
      end
    end
  end

  task automatic idle_gap;
    int n;
    n = cbr_count;
    while (cbr_count < n + 2) @(negedge clk);
    check(last_cbr - prev_cbr == T_REFI, "R9 idle refresh period", last_cbr - prev_cbr, T_REFI);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_oe_n && !req_ready && !rsp_valid,
          "R1 reset state", {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_oe_n, req_ready, rsp_valid},
          6'b111100);
    rst_n = 1;
    while (!req_ready) @(negedge clk);
    check(cbr_count == 8, "R1 init refresh count", cbr_count, 8);
    check(first_ras_cyc >= T_PWRUP, "R1 first row strobe", first_ras_cyc, T_PWRUP);
    check(acc_count == 0, "R11 no access before ready", acc_count, 0);

    idle_gap();
    idle_gap();

    // directed boundaries and byte lanes
    drive(1, 16'h0000, 16'h1111, 2'b11);
    drive(1, 16'hFFFF, 16'hEEEE, 2'b11);
    drive(1, 16'h00FF, 16'hC3C3, 2'b11);
    drive(1, 16'hFF00, 16'h3C3C, 2'b11);
    drive(0, 16'h0000, 0, 2'b11);
    drive(0, 16'hFFFF, 0, 2'b11);
    drive(0, 16'h00FF, 0, 2'b11);
    drive(0, 16'hFF00, 0, 2'b11);
    drive(1, 16'h1234, 16'hAAAA, 2'b11);
    drive(1, 16'h1234, 16'h55CD, 2'b01);
    drive(1, 16'h1234, 16'h9F00, 2'b10);
    drive(0, 16'h1234, 0, 2'b11);
    drive(0, 16'h1234, 0, 2'b01);
    drive(0, 16'h1234, 0, 2'b10);
    drive(0, 16'h4321, 0, 2'b11);

    // back-to-back traffic so refresh expiry lands at every phase (R10)
    lf = 16'hACE1;
    for (int i = 0; i < 220; i++) begin
      logic [1:0] be;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      be = (lf[1:0] == 2'b00) ? 2'b11 : lf[1:0];
      drive(lf[2], {lf[11:8], 4'h0, lf[15:12], lf[7:4]}, lf ^ 16'h0F0F, be);
      if (lf[3] && lf[5]) repeat (int'(lf[9:6])) @(negedge clk);
    end

    repeat (40) @(negedge clk);
    check(expq.size() == 0, "R12 all reads answered", expq.size(), 0);
    check(n_rsp == n_rd, "R12 response count", n_rsp, n_rd);
    check(acc_count == n_acc, "R11 one access per request", acc_count, n_acc);
    idle_gap();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule